// File: doc/BRIEF.md
# Hash Engine Input Sequencer

This block is the control and input sequencing logic in front of a hash or cipher compression core. A control port sets the operating mode, whether input arrives by DMA or by processor writes, whether the digest is drained by DMA, and whether each input word has its bytes reversed. A start bit, which clears itself, begins a new operation. The block then collects one message block of words into a running combination, starts the compression core, and reports a waiting status whenever it can take more input.

The compression rounds are a stub with a fixed latency. When the stub finishes, the digest is folded as follows: the previous digest is rotated left by one bit, then XOR-ed with the XOR of the block's words. In cipher mode it is also XOR-ed with the XOR of the key words. In cipher mode, the first words taken after reset form the key. Later starts reuse that loaded key.

Top module: `hash_seq`

## Requirements
- R1: The mode field selects hash (1) or cipher (2). The values 0 and 3 select no operation: the block sits idle with `waiting`, `wr_ready` and `dmai_req` low, and it ignores both start and input words.
- R2: `ctrl_rdata` reads back the control fields with mode in bits [1:0], DMA input enable in bit 3, DMA output enable in bit 4 and byte swap in bit 5. Bit 2 is the start bit, which clears itself and always reads 0.
- R3: A write with start set and a valid mode drops `waiting` for exactly one cycle after the write edge, then raises it. It also clears `digest` and `digest_valid`.
- R4: With DMA input disabled, the block takes one word through `wr_valid` in each cycle where `wr_ready` is high. After the last word of a block (16 in hash mode, 4 in cipher mode), the core starts by itself.
- R5: While the core is busy (64 cycles per block), `waiting`, `wr_ready` and `dmai_req` all stay low.
- R6: With DMA input enabled, `dmai_req` stays high while the block is collecting input. Each cycle with `dmai_ack` high takes one word from `dmai_data`. The request falls once the block's last word has been taken.
- R7: With swap set, every input word has its four bytes reversed before use. With swap clear, the word is used as given.
- R8: At completion, `digest` becomes rotl1(previous digest) XOR (XOR of block words), plus XOR of the key words in cipher mode, and `digest_valid` rises.
- R9: With DMA output enabled, `dmao_req` rises when a digest completes. It falls after one cycle of `dmao_ack`, and it rises again at the next completion.
- R10: In cipher mode with no key yet loaded, the first 4 words taken are key words, and the core does not start on them. Data words follow. Once the key is loaded, later starts take data words only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_mode | input | 2 | Mode to write (0 none, 1 hash, 2 cipher) |
| cfg_start | input | 1 | Start a new operation with this write |
| cfg_dma_in | input | 1 | Take input words from DMA |
| cfg_dma_out | input | 1 | Request DMA drain of digest |
| cfg_swap | input | 1 | Reverse bytes of each input word |
| ctrl_rdata | output | 6 | Control readback |
| wr_valid | input | 1 | Processor input word valid |
| wr_data | input | 32 | Processor input word |
| wr_ready | output | 1 | Processor word accepted this cycle |
| dmai_req | output | 1 | DMA input request |
| dmai_ack | input | 1 | DMA input beat |
| dmai_data | input | 32 | DMA input word |
| dmao_req | output | 1 | DMA drain request |
| dmao_ack | input | 1 | DMA drain done |
| waiting | output | 1 | Ready for input |
| core_busy | output | 1 | Compression stub running |
| digest_valid | output | 1 | Digest available |
| digest | output | 32 | Running digest |

## Verification
The checker holds the cycle-by-cycle rules on every cycle. These are: an idle mode shows no input handshake, the start bit reads zero, a start drops `waiting` on the next cycle, a busy core blocks all input, a DMA request never coexists with processor readiness, a drain request needs a valid digest, and `digest_valid` only rises after the core was busy. Only the bench scenarios can show the values. These are the digest arithmetic with and without byte swap, the exact 64-cycle stall, the burst length that ends each DMA request, the key-then-data order in cipher mode, and the reuse of a loaded key.

// File: rtl/hash_seq_pkg.sv
package hash_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_FILL,
        ST_RUN
    } seq_st_e;

    localparam logic [1:0] MODE_NONE = 2'd0;
    localparam logic [1:0] MODE_HASH = 2'd1;
    localparam logic [1:0] MODE_CIPH = 2'd2;

    function automatic logic mode_active(input logic [1:0] m);
        return (m == MODE_HASH) || (m == MODE_CIPH);
    endfunction
endpackage

// File: rtl/hash_seq_byteswap.sv
module hash_seq_byteswap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[8*b +: 8] = en ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
    end
endmodule

// File: rtl/hash_seq_core_stub.sv
module hash_seq_core_stub #(
    parameter int LAT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LAT - 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] cnt;
    } stub_t;

    stub_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == LAST);
        if (done) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (go) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/hash_seq.sv
module hash_seq
    import hash_seq_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BLK_WORDS  = 16,
    parameter int KEY_WORDS  = 4,
    parameter int CIPH_WORDS = 4,
    parameter int CORE_LAT   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_start,
    input  logic          cfg_dma_in,
    input  logic          cfg_dma_out,
    input  logic          cfg_swap,
    output logic [5:0]    ctrl_rdata,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          dmai_req,
    input  logic          dmai_ack,
    input  logic [DW-1:0] dmai_data,
    output logic          dmao_req,
    input  logic          dmao_ack,
    output logic          waiting,
    output logic          core_busy,
    output logic          digest_valid,
    output logic [DW-1:0] digest
);
    localparam int CW = $clog2(BLK_WORDS + 1);
    localparam logic [CW-1:0] BLK_LAST  = CW'(BLK_WORDS - 1);
    localparam logic [CW-1:0] KEY_LAST  = CW'(KEY_WORDS - 1);
    localparam logic [CW-1:0] CIPH_LAST = CW'(CIPH_WORDS - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [1:0]    mode;
        logic          dma_in;
        logic          dma_out;
        logic          swap;
        logic          key_loaded;
        logic [CW-1:0] cnt;
        logic [DW-1:0] blk_xor;
        logic [DW-1:0] key_xor;
        logic [DW-1:0] dig;
        logic          dig_valid;
        logic          drained;
    } seq_t;

    seq_t r_d, r_q;

    logic [DW-1:0] raw_word, sw_word;
    logic          beat, key_phase, last_beat, core_go, core_done;
    logic [CW-1:0] last_idx;

    assign raw_word = r_q.dma_in ? dmai_data : wr_data;

    hash_seq_byteswap #(.DW(DW)) u_swap (
        .en   (r_q.swap),
        .din  (raw_word),
        .dout (sw_word)
    );

    hash_seq_core_stub #(.LAT(CORE_LAT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (core_go),
        .busy  (core_busy),
        .done  (core_done)
    );

    always_comb begin
        key_phase = (r_q.mode == MODE_CIPH) && !r_q.key_loaded;
        if (key_phase)                   last_idx = KEY_LAST;
        else if (r_q.mode == MODE_CIPH)  last_idx = CIPH_LAST;
        else                             last_idx = BLK_LAST;
        beat      = (r_q.st == ST_FILL) && (r_q.dma_in ? dmai_ack : wr_valid);
        last_beat = beat && (r_q.cnt == last_idx);
        core_go   = last_beat && !key_phase;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_INIT: r_d.st = ST_FILL;
            ST_FILL: begin
                if (beat && key_phase) begin
                    r_d.key_xor = ((r_q.cnt == '0) ? '0 : r_q.key_xor) ^ sw_word;
                    if (last_beat) begin
                        r_d.key_loaded = 1'b1;
                        r_d.cnt        = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end else if (beat) begin
                    r_d.blk_xor = r_q.blk_xor ^ sw_word;
                    if (last_beat) begin
                        r_d.st  = ST_RUN;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (core_done) begin
                    r_d.st        = ST_FILL;
                    r_d.dig       = {r_q.dig[DW-2:0], r_q.dig[DW-1]} ^ r_q.blk_xor ^
                                    ((r_q.mode == MODE_CIPH) ? r_q.key_xor : '0);
                    r_d.blk_xor   = '0;
                    r_d.dig_valid = 1'b1;
                    r_d.drained   = 1'b0;
                end
            end
            default: ;
        endcase

        if (dmao_req && dmao_ack) r_d.drained = 1'b1;

        if (cfg_we) begin
            r_d.mode    = cfg_mode;
            r_d.dma_in  = cfg_dma_in;
            r_d.dma_out = cfg_dma_out;
            r_d.swap    = cfg_swap;
            if (!mode_active(cfg_mode)) begin
                r_d.st = ST_IDLE;
            end else if (cfg_start) begin
                r_d.st        = ST_INIT;
                r_d.cnt       = '0;
                r_d.blk_xor   = '0;
                r_d.dig       = '0;
                r_d.dig_valid = 1'b0;
                r_d.drained   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mode <= MODE_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_rdata   = {r_q.swap, r_q.dma_out, r_q.dma_in, 1'b0, r_q.mode};
    assign waiting      = (r_q.st == ST_FILL);
    assign wr_ready     = (r_q.st == ST_FILL) && !r_q.dma_in;
    assign dmai_req     = (r_q.st == ST_FILL) && r_q.dma_in;
    assign dmao_req     = r_q.dma_out && r_q.dig_valid && !r_q.drained;
    assign digest_valid = r_q.dig_valid;
    assign digest       = r_q.dig;
endmodule

// File: rtl/hash_seq_chk.sv
module hash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       cfg_start,
    input logic [1:0] cfg_mode,
    input logic [5:0] ctrl_rdata,
    input logic       waiting,
    input logic       wr_ready,
    input logic       dmai_req,
    input logic       dmao_req,
    input logic       core_busy,
    input logic       digest_valid
);
    a_r1_idle_no_input: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[1:0] == 2'd0 || ctrl_rdata[1:0] == 2'd3) |-> (!waiting && !wr_ready && !dmai_req));

    a_r2_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[2]);

    a_r3_init_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_start && (cfg_mode == 2'd1 || cfg_mode == 2'd2)) |=> !waiting);

    a_r5_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> (!waiting && !wr_ready && !dmai_req));

    a_r6_dma_path_only: assert property (@(posedge clk) disable iff (!rst_n)
        dmai_req |-> (ctrl_rdata[3] && !wr_ready));

    a_r9_drain_needs_digest: assert property (@(posedge clk) disable iff (!rst_n)
        dmao_req |-> (digest_valid && ctrl_rdata[4]));

    a_r8_valid_after_core: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digest_valid) |-> $past(core_busy));
endmodule

bind hash_seq hash_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_start    (cfg_start),
    .cfg_mode     (cfg_mode),
    .ctrl_rdata   (ctrl_rdata),
    .waiting      (waiting),
    .wr_ready     (wr_ready),
    .dmai_req     (dmai_req),
    .dmao_req     (dmao_req),
    .core_busy    (core_busy),
    .digest_valid (digest_valid)
);

// File: tb/hash_seq_test.sv
module hash_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_start = 1'b0, cfg_dma_in = 1'b0, cfg_dma_out = 1'b0, cfg_swap = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [5:0]  ctrl_rdata;
    logic        wr_valid = 1'b0, wr_ready;
    logic [31:0] wr_data = '0, dmai_data = '0, digest;
    logic        dmai_req, dmai_ack = 1'b0, dmao_req, dmao_ack = 1'b0;
    logic        waiting, core_busy, digest_valid;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [31:0] exp_dig = '0, key_x = '0;

    always #10 clk = ~clk;

    hash_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_start(cfg_start),
        .cfg_dma_in(cfg_dma_in), .cfg_dma_out(cfg_dma_out), .cfg_swap(cfg_swap),
        .ctrl_rdata(ctrl_rdata), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .dmai_req(dmai_req), .dmai_ack(dmai_ack), .dmai_data(dmai_data),
        .dmao_req(dmao_req), .dmao_ack(dmao_ack), .waiting(waiting), .core_busy(core_busy),
        .digest_valid(digest_valid), .digest(digest)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] w, input bit en);
        return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction

    task automatic write_ctrl(input logic [1:0] m, input bit st, input bit di, input bit dout, input bit sw);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_start = st;
        cfg_dma_in = di; cfg_dma_out = dout; cfg_swap = sw;
        @(negedge clk);
        cfg_we = 1'b0; cfg_start = 1'b0;
    endtask

    task automatic start_op(input logic [1:0] m, input bit di, input bit dout, input bit sw);
        write_ctrl(m, 1'b1, di, dout, sw);
        check("R3 waiting low in init cycle", {31'd0, waiting}, 32'd0);
        check("R2 readback start bit clear", {26'd0, ctrl_rdata}, {26'd0, sw, dout, di, 1'b0, m});
        check("R3 digest_valid cleared", {31'd0, digest_valid}, 32'd0);
        @(negedge clk);
        check("R3 waiting back high", {31'd0, waiting}, 32'd1);
        exp_dig = '0;
    endtask

    task automatic feed(input bit di, input logic [31:0] w);
        if (di) begin
            while (!dmai_req) @(negedge clk);
            dmai_ack = 1'b1; dmai_data = w;
            @(negedge clk);
            dmai_ack = 1'b0; dmai_data = '0;
        end else begin
            wr_valid = 1'b1; wr_data = w;
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0; wr_data = '0;
        end
    endtask

    task automatic run_block(input bit di, input bit sw, input bit ciph, input int n, input logic [31:0] seed);
        logic [31:0] bx = '0;
        int stall = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = seed * (i + 3) ^ (32'(i) << 24);
            bx ^= bswap(w, sw);
            feed(di, w);
            if (i == n - 2) begin
                if (di) check("R6 request held before last beat", {31'd0, dmai_req}, 32'd1);
                else    check("R4 still accepting before last word", {31'd0, wr_ready}, 32'd1);
            end
        end
        check("R6 request low after last word", {31'd0, dmai_req}, 32'd0);
        check("R4 core auto start", {31'd0, core_busy}, 32'd1);
        while (!waiting && stall < 500) begin
            stall++;
            @(negedge clk);
        end
        check("R5 stall length", 32'(stall), 32'd64);
        exp_dig = {exp_dig[30:0], exp_dig[31]} ^ bx ^ (ciph ? key_x : 32'd0);
        check(sw ? "R7 R8 digest swapped" : "R8 digest", digest, exp_dig);
        check("R8 digest_valid", {31'd0, digest_valid}, 32'd1);
    endtask

    task automatic load_key(input bit sw);
        key_x = '0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w = 32'hA5000000 + 32'(i * 7);
            key_x ^= bswap(w, sw);
            feed(1'b0, w);
        end
        check("R10 no core run on key words", {31'd0, core_busy}, 32'd0);
        check("R10 still waiting after key", {31'd0, waiting}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset waiting", {31'd0, waiting}, 32'd0);
        check("R1 reset wr_ready", {31'd0, wr_ready}, 32'd0);
        check("R9 reset dmao_req", {31'd0, dmao_req}, 32'd0);
        check("R2 reset readback", {26'd0, ctrl_rdata}, 32'd0);

        for (int m = 0; m < 4; m += 3) begin
            write_ctrl(2'(m), 1'b1, 1'b0, 1'b0, 1'b0);
            wr_valid = 1'b1; wr_data = 32'h12345678;
            repeat (3) begin
                check("R1 none mode not waiting", {31'd0, waiting}, 32'd0);
                check("R1 none mode no ready", {31'd0, wr_ready}, 32'd0);
                @(negedge clk);
            end
            wr_valid = 1'b0;
            check("R1 no digest in none mode", {31'd0, digest_valid}, 32'd0);
        end

        for (int di = 0; di < 2; di++) begin
            for (int sw = 0; sw < 2; sw++) begin
                start_op(2'd1, di[0], di[0], sw[0]);
                check("R9 no drain before digest", {31'd0, dmao_req}, 32'd0);
                for (int b = 0; b < 2; b++) begin
                    run_block(di[0], sw[0], 1'b0, 16, 32'h01030507 + 32'(b * 977 + sw * 31 + di * 5));
                    if (di == 1) begin
                        check("R9 drain raised", {31'd0, dmao_req}, 32'd1);
                        dmao_ack = 1'b1;
                        @(negedge clk);
                        dmao_ack = 1'b0;
                        check("R9 drain dropped after ack", {31'd0, dmao_req}, 32'd0);
                    end else begin
                        check("R9 no drain when disabled", {31'd0, dmao_req}, 32'd0);
                    end
                end
            end
        end

        start_op(2'd2, 1'b0, 1'b0, 1'b1);
        load_key(1'b1);
        run_block(1'b0, 1'b1, 1'b1, 4, 32'h0BADF00D);

        start_op(2'd2, 1'b1, 1'b0, 1'b1);
        run_block(1'b1, 1'b1, 1'b1, 4, 32'h7E570001);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule